// File: doc/BRIEF.md
# I/O Bank Freeze and Thaw Sequencer

This block drives the pad-control lines of a set of I/O bank channels so that the banks can be frozen safely before reconfiguration and released again afterwards. Each channel has five control lines: a slew enable, a weak pull-up, a tristate and a bus-hold, all active-low, plus an active-high configuration-done line. A freeze or thaw request makes the block walk the channels one at a time in ascending order. Each channel moves through a fixed series of steps, and a minimum gap, counted in clock cycles, separates any two steps.

A select input decides whether the software request pair or the hardware request pair may start a sequence. While a sequence runs, the block holds a busy output high and ignores every new request. When the last step of the last channel has been applied, it raises a one-cycle done pulse. Each channel has a status flag that reports frozen or thawed. A request that asks for the state a channel already has still runs the whole sequence and raises done, and it leaves every line as it was.

Top module: `io_freeze_seq`

## Requirements
- R1: After reset, every channel's five control lines are low and its frozen flag is 1. After reset, busy and done are 0.
- R2: The first freeze step of a channel drives its slew enable, weak pull-up and tristate lines low in the same cycle. Its bus-hold and config-done lines do not change in that step.
- R3: The second freeze step of a channel drives bus-hold low and config-done low, and it sets that channel's frozen flag to 1.
- R4: The first thaw step of a channel drives bus-hold high and config-done high.
- R5: The second thaw step of a channel drives weak pull-up and tristate high.
- R6: The third thaw step of a channel drives slew enable high, and it clears that channel's frozen flag to 0.
- R7: Channels are handled in ascending index order. A channel receives all of its steps before the next channel receives any step.
- R8: A request is accepted at clock edge A. Step n of the whole sequence (n counts from 0 across all channels) takes effect at edge A+1+n*(GAP_CYC+1). This puts at least GAP_CYC idle cycles between any two steps.
- R9: When src_sel is 0, only the software request inputs can start a sequence. When src_sel is 1, only the hardware request inputs can start a sequence. A request on the source that is not selected has no effect.
- R10: busy is 1 from accept edge A up to the edge of the final step. done is 1 for exactly the one cycle after that edge. Any request that arrives while busy is 1 is ignored.
- R11: A freeze request when every channel is already frozen, or a thaw request when every channel is already thawed, still runs the full sequence timing and pulses done. No control line and no flag changes.
- R12: If a freeze request and a thaw request arrive on the selected source in the same cycle, the block runs a freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel | input | 1 | Request source: 0 = software, 1 = hardware |
| sw_freeze_req | input | 1 | Software freeze request |
| sw_thaw_req | input | 1 | Software thaw request |
| hw_freeze_req | input | 1 | Hardware freeze request |
| hw_thaw_req | input | 1 | Hardware thaw request |
| slew_en_n | output | NUM_CH | Slew enable per channel, active low |
| pullup_n | output | NUM_CH | Weak pull-up per channel, active low |
| tristate_n | output | NUM_CH | Tristate per channel, active low |
| bushold_n | output | NUM_CH | Bus-hold per channel, active low |
| cfg_done | output | NUM_CH | Configuration done per channel, active high |
| chan_frozen | output | NUM_CH | Per-channel status flag: 1 = frozen |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse after the final step |

## Verification
The bench uses NUM_CH = 3 and GAP_CYC = 2. With these values a freeze sequence is 16 cycles long and a thaw sequence is 25 cycles long. Every output is compared against an arithmetic step-time model on each cycle of each sequence. This covers every step of every channel, the exact step spacing, the channel order, the edges of busy and done, and requests injected in the middle of a sequence. The bench also runs both request sources under both select values, repeats a request for the state the channels already have, and sends freeze and thaw together.

// File: rtl/io_frz_pkg.sv
package io_frz_pkg;

  typedef enum logic {
    OP_FREEZE = 1'b0,
    OP_THAW   = 1'b1
  } frz_op_e;

  function automatic int steps_per_chan(frz_op_e op);
    return (op == OP_THAW) ? 3 : 2;
  endfunction

  // Cycles from the accept edge to the edge that applies the final step.
  function automatic int seq_cycles(frz_op_e op, int nch, int gap);
    return 1 + (steps_per_chan(op) * nch - 1) * (gap + 1);
  endfunction

endpackage

// File: rtl/io_frz_src.sv
module io_frz_src
  import io_frz_pkg::*;
(
  input  logic    src_sel,
  input  logic    sw_frz,
  input  logic    sw_thaw,
  input  logic    hw_frz,
  input  logic    hw_thaw,
  output logic    req_valid,
  output frz_op_e req_op
);

  logic sel_frz, sel_thaw;

  always_comb begin
    sel_frz   = src_sel ? hw_frz  : sw_frz;
    sel_thaw  = src_sel ? hw_thaw : sw_thaw;
    req_valid = sel_frz | sel_thaw;
    // freeze has priority (R12)
    req_op    = sel_frz ? OP_FREEZE : OP_THAW;
  end

endmodule

// File: rtl/io_frz_ctrl.sv
module io_frz_ctrl
  import io_frz_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int GAP_CYC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  frz_op_e              req_op,
  output logic                 busy,
  output logic                 done,
  output logic                 step_fire,
  output logic [CW-1:0]        step_ch,
  output logic [1:0]           step_idx,
  output frz_op_e              cur_op
);

  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int GW = (GAP_CYC < 1) ? 1 : $clog2(GAP_CYC + 1);

  logic          run_q;
  frz_op_e       op_q;
  logic [CW-1:0] ch_q;
  logic [1:0]    idx_q;
  logic [GW-1:0] gap_q;
  logic [1:0]    last_idx;
  logic          last_ch;

  assign last_idx  = 2'(steps_per_chan(op_q) - 1);
  assign last_ch   = (ch_q == CW'(NUM_CH - 1));
  assign step_fire = run_q && (gap_q == '0);
  assign step_ch   = ch_q;
  assign step_idx  = idx_q;
  assign cur_op    = op_q;
  assign busy      = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      op_q  <= OP_FREEZE;
      ch_q  <= '0;
      idx_q <= '0;
      gap_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run_q) begin
        if (req_valid) begin
          run_q <= 1'b1;
          op_q  <= req_op;
          ch_q  <= '0;
          idx_q <= '0;
          gap_q <= '0;
        end
      end else if (gap_q != '0) begin
        gap_q <= gap_q - 1'b1;
      end else if (idx_q == last_idx) begin
        if (last_ch) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end else begin
          ch_q  <= ch_q + 1'b1;
          idx_q <= '0;
          gap_q <= GW'(GAP_CYC);
        end
      end else begin
        idx_q <= idx_q + 1'b1;
        gap_q <= GW'(GAP_CYC);
      end
    end
  end

  // Checker state: cycles since the previous step and since the accept edge.
  int unsigned since_fire;
  logic        fired_once;
  int unsigned run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_fire <= 0;
      fired_once <= 1'b0;
      run_cnt    <= 0;
    end else begin
      if (step_fire) since_fire <= 0;
      else if (since_fire < 32'hFFFF) since_fire <= since_fire + 1;
      if (!run_q) fired_once <= 1'b0;
      else if (step_fire) fired_once <= 1'b1;
      if (!run_q) run_cnt <= 0;
      else run_cnt <= run_cnt + 1;
    end
  end

  a_r8_step_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && fired_once) |-> (since_fire == GAP_CYC));

  a_r10_done_len: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == seq_cycles(op_q, NUM_CH, GAP_CYC)));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_op_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(op_q)));

endmodule

// File: rtl/io_frz_chan.sv
module io_frz_chan
  import io_frz_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    step_en,
  input  frz_op_e op,
  input  logic [1:0] step_idx,
  output logic    slew_n,
  output logic    pull_n,
  output logic    tri_n,
  output logic    hold_n,
  output logic    cfg_ok,
  output logic    frozen
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slew_n <= 1'b0;
      pull_n <= 1'b0;
      tri_n  <= 1'b0;
      hold_n <= 1'b0;
      cfg_ok <= 1'b0;
      frozen <= 1'b1;
    end else if (step_en) begin
      if (op == OP_FREEZE) begin
        case (step_idx)
          2'd0: begin slew_n <= 1'b0; pull_n <= 1'b0; tri_n <= 1'b0; end
          2'd1: begin hold_n <= 1'b0; cfg_ok <= 1'b0; frozen <= 1'b1; end
          default: ;
        endcase
      end else begin
        case (step_idx)
          2'd0: begin hold_n <= 1'b1; cfg_ok <= 1'b1; end
          2'd1: begin pull_n <= 1'b1; tri_n  <= 1'b1; end
          2'd2: begin slew_n <= 1'b1; frozen <= 1'b0; end
          default: ;
        endcase
      end
    end
  end

  a_r3_hold_after_group: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_n) |-> (!slew_n && !pull_n && !tri_n));

  a_r5_release_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_n) |-> (hold_n && cfg_ok));

  a_r6_slew_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slew_n) |-> (hold_n && pull_n && tri_n && cfg_ok));

  a_r6_flag_with_slew: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frozen) |-> $rose(slew_n));

endmodule

// File: rtl/io_freeze_seq.sv
module io_freeze_seq
  import io_frz_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int GAP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_sel,
  input  logic              sw_freeze_req,
  input  logic              sw_thaw_req,
  input  logic              hw_freeze_req,
  input  logic              hw_thaw_req,
  output logic [NUM_CH-1:0] slew_en_n,
  output logic [NUM_CH-1:0] pullup_n,
  output logic [NUM_CH-1:0] tristate_n,
  output logic [NUM_CH-1:0] bushold_n,
  output logic [NUM_CH-1:0] cfg_done,
  output logic [NUM_CH-1:0] chan_frozen,
  output logic              busy,
  output logic              done
);

  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic          req_valid;
  frz_op_e       req_op;
  logic          step_fire;
  logic [CW-1:0] step_ch;
  logic [1:0]    step_idx;
  frz_op_e       cur_op;
  logic [NUM_CH-1:0] chan_step;

  io_frz_src u_src (
    .src_sel   (src_sel),
    .sw_frz    (sw_freeze_req),
    .sw_thaw   (sw_thaw_req),
    .hw_frz    (hw_freeze_req),
    .hw_thaw   (hw_thaw_req),
    .req_valid (req_valid),
    .req_op    (req_op)
  );

  io_frz_ctrl #(.NUM_CH(NUM_CH), .GAP_CYC(GAP_CYC)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .busy      (busy),
    .done      (done),
    .step_fire (step_fire),
    .step_ch   (step_ch),
    .step_idx  (step_idx),
    .cur_op    (cur_op)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign chan_step[g] = step_fire && (step_ch == CW'(g));
    io_frz_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (chan_step[g]),
      .op       (cur_op),
      .step_idx (step_idx),
      .slew_n   (slew_en_n[g]),
      .pull_n   (pullup_n[g]),
      .tri_n    (tristate_n[g]),
      .hold_n   (bushold_n[g]),
      .cfg_ok   (cfg_done[g]),
      .frozen   (chan_frozen[g])
    );
  end

  a_r7_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_step));

  a_r7_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(step_ch)) |-> (step_ch == $past(step_ch) + 1'b1));

endmodule

// File: tb/io_freeze_seq_bench.sv
module io_freeze_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int GAP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_sel = 1'b0;
  logic sw_f = 1'b0, sw_t = 1'b0, hw_f = 1'b0, hw_t = 1'b0;
  logic [NCH-1:0] slew_n, pull_n, tri_n, hold_n, cfg, frz;
  logic busy, done;

  logic [NCH-1:0] m_slew, m_pull, m_tri, m_hold, m_cfg, m_frz;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_freeze_seq #(.NUM_CH(NCH), .GAP_CYC(GAP)) u_io_freeze_seq (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
    .sw_freeze_req(sw_f), .sw_thaw_req(sw_t),
    .hw_freeze_req(hw_f), .hw_thaw_req(hw_t),
    .slew_en_n(slew_n), .pullup_n(pull_n), .tristate_n(tri_n),
    .bushold_n(hold_n), .cfg_done(cfg), .chan_frozen(frz),
    .busy(busy), .done(done)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_all(string req);
    chk(req, "slew_en_n", 32'(slew_n), 32'(m_slew));
    chk(req, "pullup_n", 32'(pull_n), 32'(m_pull));
    chk(req, "tristate_n", 32'(tri_n), 32'(m_tri));
    chk(req, "bushold_n", 32'(hold_n), 32'(m_hold));
    chk(req, "cfg_done", 32'(cfg), 32'(m_cfg));
    chk(req, "chan_frozen", 32'(frz), 32'(m_frz));
  endtask

  // Model of sequence step n (R2-R7).
  task automatic model_step(bit thaw, int n);
    int spc = thaw ? 3 : 2;
    int ch = n / spc;
    int s = n % spc;
    if (!thaw) begin
      if (s == 0) begin m_slew[ch] = 0; m_pull[ch] = 0; m_tri[ch] = 0; end
      else begin m_hold[ch] = 0; m_cfg[ch] = 0; m_frz[ch] = 1; end
    end else begin
      if (s == 0) begin m_hold[ch] = 1; m_cfg[ch] = 1; end
      else if (s == 1) begin m_pull[ch] = 1; m_tri[ch] = 1; end
      else begin m_slew[ch] = 1; m_frz[ch] = 0; end
    end
  endtask

  // Called at a negedge; drives the request for one edge and follows the sequence.
  task automatic run_seq(logic fs, logic ts, logic fh, logic th,
                         bit exp_thaw, bit poke, string req);
    int spc = exp_thaw ? 3 : 2;
    int nsteps = spc * NCH;
    int tlast = 1 + (nsteps - 1) * (GAP + 1);
    sw_f = fs; sw_t = ts; hw_f = fh; hw_t = th;
    @(posedge clk);
    for (int t = 0; t <= tlast + 2; t++) begin
      if (t > 0) @(posedge clk);
      @(negedge clk);
      if (t == 0) begin sw_f = 0; sw_t = 0; hw_f = 0; hw_t = 0; end
      // R10: requests during busy are ignored
      if (poke && t == 3) begin sw_f = 1; sw_t = 1; hw_f = 1; hw_t = 1; end
      if (poke && t == 6) begin sw_f = 0; sw_t = 0; hw_f = 0; hw_t = 0; end
      for (int n = 0; n < nsteps; n++)
        if (t == 1 + n * (GAP + 1)) model_step(exp_thaw, n);
      cmp_all(req);
      chk("R10", "busy", 32'(busy), 32'(t < tlast));
      chk("R10", "done", 32'(done), 32'(t == tlast));
    end
  endtask

  // R9: pulse an unselected request and confirm nothing moves.
  task automatic ignored_req(logic fs, logic ts, logic fh, logic th);
    sw_f = fs; sw_t = ts; hw_f = fh; hw_t = th;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); @(negedge clk);
      cmp_all("R9");
      chk("R9", "busy", 32'(busy), 32'd0);
      chk("R9", "done", 32'(done), 32'd0);
    end
    sw_f = 0; sw_t = 0; hw_f = 0; hw_t = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_slew = '0; m_pull = '0; m_tri = '0; m_hold = '0; m_cfg = '0; m_frz = '1;
    repeat (3) @(negedge clk);
    cmp_all("R1");
    chk("R1", "busy", 32'(busy), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_all("R1");

    src_sel = 1'b0;
    run_seq(0, 1, 0, 0, 1'b1, 1'b1, "R4 R5 R6 R7 R8");
    run_seq(0, 1, 0, 0, 1'b1, 1'b0, "R11");
    src_sel = 1'b1;
    ignored_req(1, 0, 0, 0);
    run_seq(0, 0, 1, 0, 1'b0, 1'b1, "R2 R3 R7 R8 R9");
    run_seq(0, 0, 1, 0, 1'b0, 1'b0, "R11");
    src_sel = 1'b0;
    ignored_req(0, 0, 0, 1);
    run_seq(0, 1, 0, 0, 1'b1, 1'b0, "R4 R5 R6 R9");
    run_seq(1, 1, 0, 0, 1'b0, 1'b0, "R12");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule